// File: doc/BRIEF.md
# Rotating-Priority Shared Bus Arbiter

This block decides which master owns a single shared external bus. Up to eight peer processors each raise a request line and receive a one-hot grant. A host master has its own request and grant path and wins over every peer whenever the bus is free. Among the peers, priority rotates: the peer granted last drops to the lowest priority in the next contest. Only ownership and grant signalling are modelled. Data, addresses and the transactions themselves belong to the surrounding logic.

The owner keeps the bus while it requests or holds its lock line, so a read-modify-write sequence is never split. A programmable hold limit forces an unlocked owner off the bus once it has held it for that many cycles while someone else is waiting. A host backoff input pre-empts a peer even when it is locked. The aborted peer gets a retry flag, which is cleared when that peer is next granted. A grant never passes straight from one holder to another: at least one idle cycle separates two owners. All outputs come from registers, so a request sampled at a clock edge shows up as a grant in the cycle after that edge.

Top module: `rr_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, every retry flag is clear, and the rotation pointer selects peer 0 as the highest-priority peer.
- R2: At most one grant among all peer grants and the host grant is asserted in any cycle.
- R3: A grant never moves directly from one holder to another. Between two different owners there is at least one cycle with no grant.
- R4: When the bus is free and the host does not want it, the winner is the first requesting peer found by scanning upward from the rotation pointer, wrapping from the highest peer index to 0. Each peer grant moves the pointer to winner+1 modulo the peer count. Idle cycles and host grants leave the pointer unchanged.
- R5: When the bus is free and host_req or host_backoff is high, the host is granted in the next cycle, ahead of any peer request.
- R6: A peer owner keeps its grant while its request bit or its lock bit is high, unless R7 or R9 applies. When both are low, its grant drops in the next cycle.
- R7: With hold_limit = L nonzero, once a peer has held the grant for L cycles while another peer request, host_req or host_backoff is pending and its lock bit is low, its grant drops in the next cycle. hold_limit = 0 disables this release.
- R8: While the owner's lock bit is high and host_backoff is low, the hold limit never removes its grant.
- R9: When host_backoff is high while a peer owns the bus, that peer's grant drops in the next cycle regardless of lock. If host_backoff or host_req is still high, host_gnt rises one cycle later.
- R10: A peer aborted by backoff gets its peer_retry bit set in the cycle its grant drops. The bit stays set until that peer is granted again, and clears in the same cycle as that grant.
- R11: The host keeps host_gnt while host_req or host_backoff is high, and releases in the next cycle after both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_limit | input | HOLD_W | Fairness hold limit in cycles; 0 disables it |
| peer_req | input | N_PEERS | Per-peer bus request |
| peer_lock | input | N_PEERS | Per-peer lock; only the owner's bit has effect |
| host_req | input | 1 | Host bus request |
| host_backoff | input | 1 | Host forced backoff; aborts a peer owner |
| peer_gnt | output | N_PEERS | One-hot peer grant |
| host_gnt | output | 1 | Host grant |
| peer_retry | output | N_PEERS | Per-peer flag that a transaction was aborted and must be repeated |

## Verification
The hardest state to reach is a backoff that lands on a locked peer that has already run past its hold limit while another peer waits. In that state lock, fairness and pre-emption all act in the same cycle. The stimulus table first grants a peer with its lock held across the limit to show that the lock wins over fairness. It then pulses backoff on a locked owner and follows the retry flag through the host tenure until that peer is granted again. Wrap-around of the rotation pointer is reached by granting the top peer. A disabled hold limit is shown by keeping one peer on the bus for many cycles against a competing request.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_PEER = 2'd1,
    OWN_HOST = 2'd2
  } owner_e;

  // rotation step: index after idx, wrapping at n
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // position reached by walking off steps upward from base, wrapping at n
  function automatic int unsigned wrap_add(int unsigned base, int unsigned off,
                                           int unsigned n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);
  import arb_pkg::*;

  logic [N-1:0] rot;

  // rotated request view: rot[0] is the peer at the pointer
  for (genvar g = 0; g < N; g++) begin : g_rot
    assign rot[g] = req[wrap_add(int'(ptr), g, N)];
  end

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        win_vld = 1'b1;
        win_idx = IW'(wrap_add(int'(ptr), k, N));
      end
    end
  end

endmodule

// File: rtl/arb_hold_timer.sv
module arb_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         hold,
  input  logic [W-1:0] limit,
  output logic         reached
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt;

  // cnt is the number of cycles the current owner has seen its grant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= W'(1);
    end else if (hold && cnt != CNT_MAX) begin
      cnt <= cnt + W'(1);
    end
  end

  assign reached = (limit != '0) && (cnt >= limit);

endmodule

// File: rtl/arb_retry_flags.sv
module arb_retry_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[g] <= 1'b0;
      else if (set_vec[g]) flags[g] <= 1'b1;
      else if (clr_vec[g]) flags[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int N_PEERS = 8,
  parameter int HOLD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] hold_limit,
  input  logic [N_PEERS-1:0] peer_req,
  input  logic [N_PEERS-1:0] peer_lock,
  input  logic              host_req,
  input  logic              host_backoff,
  output logic [N_PEERS-1:0] peer_gnt,
  output logic              host_gnt,
  output logic [N_PEERS-1:0] peer_retry
);
  import arb_pkg::*;

  localparam int IW = (N_PEERS > 1) ? $clog2(N_PEERS) : 1;
  localparam logic [N_PEERS-1:0] ONE = {{(N_PEERS-1){1'b0}}, 1'b1};

  owner_e        own_state;
  logic [IW-1:0] own_idx;
  logic [IW-1:0] rot_ptr;

  // named internal events
  logic              host_want;
  logic              bus_free;
  logic              pick_vld;
  logic [IW-1:0]     pick_idx;
  logic [N_PEERS-1:0] own_mask;
  logic              owner_req;
  logic              owner_lock;
  logic              others_pend;
  logic              limit_hit;
  logic              fair_expire;
  logic              abort_evt;
  logic              peer_release;
  logic              host_release;
  logic              grant_host_evt;
  logic              grant_peer_evt;
  logic [N_PEERS-1:0] retry_set;
  logic [N_PEERS-1:0] retry_clr;

  assign host_want = host_req | host_backoff;
  assign bus_free  = (own_state == OWN_NONE);
  assign own_mask  = ONE << own_idx;
  assign owner_req  = |(peer_req & own_mask);
  assign owner_lock = |(peer_lock & own_mask);
  assign others_pend = host_want | (|(peer_req & ~own_mask));

  arb_rr_pick #(.N(N_PEERS), .IW(IW)) u_pick (
    .req    (peer_req),
    .ptr    (rot_ptr),
    .win_vld(pick_vld),
    .win_idx(pick_idx)
  );

  assign grant_host_evt = bus_free && host_want;
  assign grant_peer_evt = bus_free && !host_want && pick_vld;

  arb_hold_timer #(.W(HOLD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (grant_peer_evt),
    .hold   (own_state == OWN_PEER),
    .limit  (hold_limit),
    .reached(limit_hit)
  );

  assign fair_expire  = (own_state == OWN_PEER) && limit_hit && others_pend &&
                        !owner_lock;
  assign abort_evt    = (own_state == OWN_PEER) && host_backoff;
  assign peer_release = (own_state == OWN_PEER) &&
                        (abort_evt || fair_expire || (!owner_req && !owner_lock));
  assign host_release = (own_state == OWN_HOST) && !host_want;

  assign retry_set = abort_evt ? own_mask : '0;
  assign retry_clr = grant_peer_evt ? (ONE << pick_idx) : '0;

  arb_retry_flags #(.N(N_PEERS)) u_retry (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(retry_set),
    .clr_vec(retry_clr),
    .flags  (peer_retry)
  );

  // ownership state; a release always passes through OWN_NONE for one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_state <= OWN_NONE;
      own_idx   <= '0;
      rot_ptr   <= '0;
    end else begin
      unique case (own_state)
        OWN_NONE: begin
          if (grant_host_evt) begin
            own_state <= OWN_HOST;
          end else if (grant_peer_evt) begin
            own_state <= OWN_PEER;
            own_idx   <= pick_idx;
            rot_ptr   <= IW'(wrap_next(int'(pick_idx), N_PEERS));
          end
        end
        OWN_PEER: if (peer_release) own_state <= OWN_NONE;
        OWN_HOST: if (host_release) own_state <= OWN_NONE;
        default:  own_state <= OWN_NONE;
      endcase
    end
  end

  assign peer_gnt = (own_state == OWN_PEER) ? own_mask : '0;
  assign host_gnt = (own_state == OWN_HOST);

endmodule

// File: rtl/rr_bus_arbiter_chk.sv
module rr_bus_arbiter_chk #(
  parameter int N_PEERS = 8,
  parameter int HOLD_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HOLD_W-1:0] hold_limit,
  input logic [N_PEERS-1:0] peer_req,
  input logic [N_PEERS-1:0] peer_lock,
  input logic              host_req,
  input logic              host_backoff,
  input logic [N_PEERS-1:0] peer_gnt,
  input logic              host_gnt,
  input logic [N_PEERS-1:0] peer_retry,
  input logic              bus_free,
  input logic              abort_evt
);
  logic [N_PEERS:0] all_gnt;
  assign all_gnt = {host_gnt, peer_gnt};

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(all_gnt) <= 1);

  p_no_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|all_gnt) && (|$past(all_gnt))) |-> (all_gnt == $past(all_gnt)));

  p_host_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && (host_req || host_backoff)) |=> host_gnt);

  p_backoff_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|peer_gnt) && host_backoff) |=> (peer_gnt == '0));

  p_abort_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> ((peer_retry & $past(peer_gnt)) == $past(peer_gnt)));

  p_host_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && (host_req || host_backoff)) |=> host_gnt);

  for (genvar g = 0; g < N_PEERS; g++) begin : g_peer
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (peer_gnt[g] && peer_lock[g] && !host_backoff) |=> peer_gnt[g]);

    p_retry_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(peer_retry[g]) |-> ($past(peer_gnt[g]) && $past(host_backoff)));
  end

endmodule

bind rr_bus_arbiter rr_bus_arbiter_chk #(.N_PEERS(N_PEERS), .HOLD_W(HOLD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_limit  (hold_limit),
  .peer_req    (peer_req),
  .peer_lock   (peer_lock),
  .host_req    (host_req),
  .host_backoff(host_backoff),
  .peer_gnt    (peer_gnt),
  .host_gnt    (host_gnt),
  .peer_retry  (peer_retry),
  .bus_free    (bus_free),
  .abort_evt   (abort_evt)
);

// File: tb/test_rr_bus_arbiter.sv
module test_rr_bus_arbiter;

  localparam int NP = 8;
  localparam int HW = 8;
  localparam int ROWS = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] hold_limit = 8'd3;
  logic [NP-1:0] peer_req = '0;
  logic [NP-1:0] peer_lock = '0;
  logic          host_req = 1'b0;
  logic          host_backoff = 1'b0;
  logic [NP-1:0] peer_gnt;
  logic          host_gnt;
  logic [NP-1:0] peer_retry;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rr_bus_arbiter #(.N_PEERS(NP), .HOLD_W(HW)) i_rr_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .hold_limit(hold_limit),
    .peer_req(peer_req), .peer_lock(peer_lock),
    .host_req(host_req), .host_backoff(host_backoff),
    .peer_gnt(peer_gnt), .host_gnt(host_gnt), .peer_retry(peer_retry)
  );

  // row: req, lock, host_req, backoff | expected peer_gnt, host_gnt, retry
  // inputs held for one edge, outputs checked in the following cycle
  localparam logic [34:0] TBL [ROWS] = '{
    {8'h05, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R4 peer0 first
    {8'h05, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R6
    {8'h05, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R7 third cycle
    {8'h05, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R7 limit release
    {8'h05, 8'h00, 1'b0, 1'b0, 8'h04, 1'b0, 8'h00}, // R4 rotates to peer2
    {8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 drop req
    {8'h01, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R4 wrap scan
    {8'h81, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R8
    {8'h81, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R8
    {8'h81, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R8 lock beats limit
    {8'h80, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R6 lock alone holds
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 release
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 1'b0, 8'h00}, // R4 peer7
    {8'h80, 8'h00, 1'b1, 1'b0, 8'h80, 1'b0, 8'h00}, // R7
    {8'h80, 8'h00, 1'b1, 1'b0, 8'h80, 1'b0, 8'h00}, // R7
    {8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R7 host pending
    {8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00}, // R5 host first
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R11 host release
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 1'b0, 8'h00}, // R4 pointer wrapped
    {8'h80, 8'h80, 1'b0, 1'b1, 8'h00, 1'b0, 8'h80}, // R9 abort locked
    {8'h80, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 8'h80}, // R9 host after gap
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80}, // R11 / R10 held
    {8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 1'b0, 8'h00}, // R10 cleared
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}  // R6
  };

  function automatic string row_tag(int i);
    case (i)
      0, 4, 6, 12, 18:       return "R4";
      2, 3, 13, 14, 15:      return "R7";
      7, 8, 9:               return "R8";
      16:                    return "R5";
      17:                    return "R11";
      19, 20:                return "R9";
      21, 22:                return "R10";
      default:               return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic [NP-1:0] eg,
                           input logic eh, input logic [NP-1:0] er);
    check(peer_gnt === eg, tag, "peer_gnt", 32'(peer_gnt), 32'(eg));
    check(host_gnt === eh, tag, "host_gnt", 32'(host_gnt), 32'(eh));
    check(peer_retry === er, tag, "peer_retry", 32'(peer_retry), 32'(er));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    peer_req = '0; peer_lock = '0; host_req = 1'b0; host_backoff = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0] prev;
    repeat (2) @(negedge clk);
    // R1 reset state
    check_out("R1", 8'h00, 1'b0, 8'h00);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < ROWS; i++) begin
      {peer_req, peer_lock, host_req, host_backoff} = TBL[i][34:17];
      @(negedge clk);
      check_out(row_tag(i), TBL[i][16:9], TBL[i][8], TBL[i][7:0]);
    end

    // R1 pointer at peer 0 after reset: all request, peer0 wins
    do_reset();
    peer_req = 8'hFF;
    @(negedge clk);
    check_out("R1", 8'h01, 1'b0, 8'h00);

    // R7 disabled when hold_limit is 0; R2/R3 observed per cycle
    hold_limit = 8'd0;
    peer_req = 8'h03;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check(peer_gnt === 8'h01, "R7", "limit0 hold", 32'(peer_gnt), 32'h01);
    end
    peer_req = 8'h02;
    @(negedge clk);
    check(peer_gnt === 8'h00, "R3", "gap cycle", 32'(peer_gnt), 32'h00);
    @(negedge clk);
    check(peer_gnt === 8'h02, "R4", "next peer", 32'(peer_gnt), 32'h02);

    // R5 backoff on idle bus grants host; R2 never two grants
    peer_req = 8'h00;
    @(negedge clk);
    host_backoff = 1'b1;
    peer_req = 8'h10;
    @(negedge clk);
    check(host_gnt === 1'b1, "R5", "backoff idle", 32'(host_gnt), 32'h1);
    check(peer_gnt === 8'h00, "R2", "single grant", 32'(peer_gnt), 32'h00);
    host_backoff = 1'b0;
    @(negedge clk);
    check(host_gnt === 1'b0, "R11", "host release", 32'(host_gnt), 32'h0);
    @(negedge clk);
    check(peer_gnt === 8'h10, "R4", "peer4 after host", 32'(peer_gnt), 32'h10);

    // R10 retry cleared by reset, R9 abort from normal hold
    hold_limit = 8'd3;
    host_backoff = 1'b1;
    prev = peer_gnt;
    @(negedge clk);
    check(peer_retry === prev, "R10", "retry set", 32'(peer_retry), 32'(prev));
    do_reset();
    @(negedge clk);
    check_out("R1", 8'h00, 1'b0, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule